// File: doc/BRIEF.md
# Bus Master Burst Sequencer

This block runs the data phase of a bus-master tenure that moves words between on-chip transmit/receive FIFOs and system memory. Once the arbiter grants the bus, it issues a series of back-to-back single-word transfers to rising, contiguous word addresses. All transfers in one tenure go in the same direction. It then returns the bus with a one-cycle release pulse. Arbitration, descriptor handling and FIFO storage are outside the block.

The transfer stream is handshaked. While a transfer is pending, the block holds `xfer_addr`, `xfer_be` and `xfer_write`, and `xfer_strobe` marks the first cycle of that transfer. The memory side applies back-pressure by holding `xfer_rdy` low. A transfer completes only on a clock edge where `xfer_rdy` is high. The next transfer, if any, starts in the following cycle.

Two end-of-burst policies are selectable:
- Count-limited mode (`mode_thr`=0) caps the burst at a programmable length.
- Threshold mode (`mode_thr`=1) keeps going until the relevant FIFO reaches its watermark.

In both modes, an expired bus-activity timer, a preempt request or an external early-stop condition ends the burst after the transfer in progress.

Top module: `dma_burst_ctrl`

## Requirements
- R1: After reset, `xfer_be` is 4'b0000, `xfer_strobe`, `xfer_last` and `bus_release` are 0, and the burst-length limit holds 16.
- R2: A burst starts only on a clock edge where `grant` is high while the block is idle. Its first address is `start_addr`, and `xfer_strobe` is high in exactly the first cycle of each transfer. `grant` is ignored while a burst is running.
- R3: A transfer completes only on an edge with `xfer_rdy` high. Until then `xfer_addr`, `xfer_be` and `xfer_write` hold still. `xfer_be` is 4'b1111 while a transfer is pending and 4'b0000 otherwise.
- R4: Each completed non-final transfer advances the address by 4.
- R5: `xfer_write` equals the value of `dir_write` captured at the grant and stays the same for the whole burst (1 = write to memory).
- R6: With `mode_thr`=0, a burst has at most `limit` transfers. `limit` is loaded from `limit_val` on an edge with `limit_we` high; a value of 0 acts as 1.
- R7: With `mode_thr`=1 and a read burst, the pending transfer is final when `tx_level + 1 >= tx_high`.
- R8: With `mode_thr`=1 and a write burst, the pending transfer is final when `rx_level <= rx_low + 1`.
- R9: The activity timer loads `timer_reload` at the grant and counts down once per clock while the burst runs. The transfer pending when it reads 0 is final, so a reload of T with no wait states gives T+1 transfers.
- R10: A `preempt` pulse seen during a pending transfer is remembered, and that transfer becomes the final one. `early_stop` high makes the pending transfer final in either mode.
- R11: `xfer_last` is high with the final transfer. `bus_release` is a single-cycle pulse in the cycle after the final transfer completes, after which the block is idle.
- R12: With `mode_thr`=1 the count limit has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| grant | input | 1 | Bus ownership granted |
| dir_write | input | 1 | Direction for the next burst, 1 = write to memory |
| start_addr | input | 32 | Byte address of the first word |
| mode_thr | input | 1 | 0 = count-limited, 1 = threshold mode |
| limit_we | input | 1 | Load strobe for the burst-length limit |
| limit_val | input | 8 | New burst-length limit |
| timer_reload | input | 16 | Activity timer start value |
| tx_level | input | 6 | Transmit FIFO fill level |
| tx_high | input | 6 | Transmit FIFO high watermark |
| rx_level | input | 6 | Receive FIFO fill level |
| rx_low | input | 6 | Receive FIFO low watermark |
| early_stop | input | 1 | FIFO or status condition requesting an early end |
| preempt | input | 1 | Preemption request |
| xfer_rdy | input | 1 | Pending transfer accepted this edge |
| xfer_addr | output | 32 | Transfer byte address |
| xfer_be | output | 4 | Active byte lanes |
| xfer_write | output | 1 | Transfer direction |
| xfer_strobe | output | 1 | First cycle of a transfer |
| xfer_last | output | 1 | Pending transfer is the final one |
| bus_release | output | 1 | Bus returned, one-cycle pulse |

## Verification
The bench stretches transfers with wait states and checks that address and byte lanes do not move early. A design that advanced on strobe rather than on ready would skip words.

Preempt is given as a one-cycle pulse during the stalled first cycle of a transfer. A design that failed to latch it would run to the count limit.

In threshold mode, the bench moves the FIFO levels as each transfer completes and programs a small count limit. This catches a final flag that is one transfer off, and a threshold mode that still obeys the count limit.

The timer test expects exactly reload+1 transfers, which exposes an off-by-one in the load or the decrement.

// File: rtl/dma_burst_pkg.sv
package dma_burst_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_XFER = 2'd1,
    ST_REL  = 2'd2
  } burst_st_e;

  localparam int WORD_BYTES  = 4;
  localparam int LIMIT_RESET = 16;
endpackage

// File: rtl/dma_act_timer.sv
module dma_act_timer #(
  parameter int TW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [TW-1:0] reload,
  input  logic          run,
  output logic          expired
);
  logic [TW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cnt_q <= '0;
    else if (load)              cnt_q <= reload;
    else if (run && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired = (cnt_q == '0);

  // R9
  timer_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && run && !load) |=> expired);
endmodule

// File: rtl/dma_addr_gen.sv
module dma_addr_gen #(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] base,
  input  logic          adv,
  output logic [AW-1:0] addr,
  output logic [CW-1:0] count
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr  <= '0;
      count <= '0;
    end else if (load) begin
      addr  <= base;
      count <= '0;
    end else if (adv) begin
      addr  <= addr + AW'(STEP);
      count <= count + 1'b1;
    end
  end

  // R4
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !load) |=> addr == $past(addr) + AW'(STEP));
endmodule

// File: rtl/dma_end_logic.sv
module dma_end_logic #(
  parameter int CW = 8,
  parameter int FW = 6
) (
  input  logic          mode_thr,
  input  logic          is_write,
  input  logic [CW-1:0] count,
  input  logic [CW-1:0] limit,
  input  logic [FW-1:0] tx_level,
  input  logic [FW-1:0] tx_high,
  input  logic [FW-1:0] rx_level,
  input  logic [FW-1:0] rx_low,
  input  logic          early_stop,
  input  logic          preempt_any,
  input  logic          timer_exp,
  output logic          final_xfer
);
  logic count_hit, thr_hit;

  always_comb begin
    count_hit = ({1'b0, count} + 1'b1) >= {1'b0, limit};
    if (is_write) thr_hit = {1'b0, rx_level} <= ({1'b0, rx_low} + 1'b1);
    else          thr_hit = ({1'b0, tx_level} + 1'b1) >= {1'b0, tx_high};
    final_xfer = early_stop | preempt_any | timer_exp |
                 (mode_thr ? thr_hit : count_hit);
  end
endmodule

// File: rtl/dma_burst_ctrl.sv
module dma_burst_ctrl
  import dma_burst_pkg::*;
#(
  parameter int AW = 32,
  parameter int CW = 8,
  parameter int TW = 16,
  parameter int FW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          grant,
  input  logic          dir_write,
  input  logic [AW-1:0] start_addr,
  input  logic          mode_thr,
  input  logic          limit_we,
  input  logic [CW-1:0] limit_val,
  input  logic [TW-1:0] timer_reload,
  input  logic [FW-1:0] tx_level,
  input  logic [FW-1:0] tx_high,
  input  logic [FW-1:0] rx_level,
  input  logic [FW-1:0] rx_low,
  input  logic          early_stop,
  input  logic          preempt,
  input  logic          xfer_rdy,
  output logic [AW-1:0] xfer_addr,
  output logic [3:0]    xfer_be,
  output logic          xfer_write,
  output logic          xfer_strobe,
  output logic          xfer_last,
  output logic          bus_release
);
  burst_st_e    st_q;
  logic         dir_q, fresh_q, pre_q;
  logic [CW-1:0] limit_q, count;
  logic         start, in_xfer, done_xfer, step, timer_exp, final_xfer;

  assign in_xfer   = (st_q == ST_XFER);
  assign start     = (st_q == ST_IDLE) && grant;
  assign done_xfer = in_xfer && xfer_rdy;
  assign step      = done_xfer && !final_xfer;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) limit_q <= CW'(LIMIT_RESET);
    else if (limit_we) limit_q <= limit_val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      dir_q   <= 1'b0;
      fresh_q <= 1'b0;
      pre_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (grant) begin
          st_q    <= ST_XFER;
          dir_q   <= dir_write;
          fresh_q <= 1'b1;
          pre_q   <= 1'b0;
        end
        ST_XFER: begin
          if (preempt) pre_q <= 1'b1;
          fresh_q <= step;
          if (done_xfer && final_xfer) st_q <= ST_REL;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  dma_act_timer #(.TW(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(start), .reload(timer_reload),
    .run(in_xfer), .expired(timer_exp)
  );

  dma_addr_gen #(.AW(AW), .CW(CW), .STEP(WORD_BYTES)) u_addr (
    .clk(clk), .rst_n(rst_n), .load(start), .base(start_addr),
    .adv(step), .addr(xfer_addr), .count(count)
  );

  dma_end_logic #(.CW(CW), .FW(FW)) u_end (
    .mode_thr(mode_thr), .is_write(dir_q), .count(count), .limit(limit_q),
    .tx_level(tx_level), .tx_high(tx_high), .rx_level(rx_level),
    .rx_low(rx_low), .early_stop(early_stop),
    .preempt_any(preempt | pre_q), .timer_exp(timer_exp),
    .final_xfer(final_xfer)
  );

  assign xfer_be     = in_xfer ? 4'b1111 : 4'b0000;
  assign xfer_write  = dir_q;
  assign xfer_strobe = in_xfer && fresh_q;
  assign xfer_last   = in_xfer && final_xfer;
  assign bus_release = (st_q == ST_REL);

  // R3
  hold_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !xfer_rdy) |=> in_xfer && $stable(xfer_addr) && $stable(xfer_write));
  // R5
  dir_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !xfer_rdy) |=> $stable(xfer_write));
  // R11
  release_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && xfer_rdy && xfer_last) |=> bus_release);
  // R11
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |=> !bus_release && !in_xfer);
  // R2
  grant_needed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!in_xfer ##1 in_xfer) |-> $past(grant));
  // R6
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_xfer && !mode_thr && !limit_we && limit_q != 0) |-> count < limit_q);
endmodule

// File: tb/dma_burst_ctrl_test.sv
module dma_burst_ctrl_test;
  localparam int CLK_NS = 10;

  logic clk = 0, rst_n = 0;
  logic grant = 0, dir_write = 0, mode_thr = 0, limit_we = 0;
  logic [31:0] start_addr = 0;
  logic [7:0] limit_val = 0;
  logic [15:0] timer_reload = 16'hFFFF;
  logic [5:0] tx_level = 0, tx_high = 0, rx_level = 0, rx_low = 0;
  logic early_stop = 0, preempt = 0, xfer_rdy = 0;
  logic [31:0] xfer_addr;
  logic [3:0] xfer_be;
  logic xfer_write, xfer_strobe, xfer_last, bus_release;

  int total = 0, bad = 0;

  always #(CLK_NS/2) clk = ~clk;

  dma_burst_ctrl uut (
    .clk(clk), .rst_n(rst_n), .grant(grant), .dir_write(dir_write),
    .start_addr(start_addr), .mode_thr(mode_thr), .limit_we(limit_we),
    .limit_val(limit_val), .timer_reload(timer_reload), .tx_level(tx_level),
    .tx_high(tx_high), .rx_level(rx_level), .rx_low(rx_low),
    .early_stop(early_stop), .preempt(preempt), .xfer_rdy(xfer_rdy),
    .xfer_addr(xfer_addr), .xfer_be(xfer_be), .xfer_write(xfer_write),
    .xfer_strobe(xfer_strobe), .xfer_last(xfer_last), .bus_release(bus_release)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // stop_kind: 0 none, 1 preempt pulse, 2 early_stop held
  task automatic run_burst(input string req, input logic md, input logic wr,
                           input logic [31:0] base, input logic stall,
                           input int stop_kind, input int stop_at, input int exp_n);
    int n = 0, sub = 0, cyc = 0;
    logic [31:0] ea = base;
    logic done = 0, last_ok = 1, rel_seen = 0;
    mode_thr = md; dir_write = wr; start_addr = base;
    @(negedge clk) grant = 1;
    @(negedge clk) grant = stall;  // R2 grant ignored while busy
    while (!done && cyc < 400) begin
      cyc++;
      if (bus_release) begin
        rel_seen = 1; done = 1;
      end else begin
        if (stop_kind == 1 && n == stop_at && sub == 0) preempt = 1;
        if (stop_kind == 2 && n == stop_at) early_stop = 1;
        xfer_rdy = stall ? (sub == 1) : 1'b1;
        #1;
        check({req, " R3 be"}, 32'(xfer_be), 32'hF);
        check({req, " R4 addr"}, xfer_addr, ea);
        check({req, " R5 dir"}, 32'(xfer_write), 32'(wr));
        check({req, " R2 strobe"}, 32'(xfer_strobe), 32'(sub == 0));
        if (xfer_rdy && xfer_last && n + 1 != exp_n) last_ok = 0;
        if (xfer_rdy && !xfer_last && n + 1 == exp_n) last_ok = 0;
        @(posedge clk);
        @(negedge clk);
        preempt = 0;
        if (xfer_rdy) begin
          n++; ea += 4; sub = 0;
          if (wr) rx_level = rx_level - 1'b1;
          else    tx_level = tx_level + 1'b1;
        end else sub = 1;
        xfer_rdy = 0;
      end
    end
    grant = 0; early_stop = 0;
    check({req, " transfer count"}, n, exp_n);
    check({req, " R11 last flag"}, 32'(last_ok), 1);
    check({req, " R11 release"}, 32'(rel_seen), 1);
    @(negedge clk);
    check({req, " R11 idle after release"}, {27'd0, xfer_be, bus_release}, 0);
  endtask

  task automatic t_reset;
    check("R1 be", 32'(xfer_be), 0);
    check("R1 strobe/last/release", {29'd0, xfer_strobe, xfer_last, bus_release}, 0);
  endtask

  task automatic t_default_limit;  // R1 R6
    run_burst("R6 default", 0, 0, 32'h1000, 0, 0, 0, 16);
  endtask

  task automatic t_prog_limit;  // R6 R3 wait states
    @(negedge clk) begin limit_we = 1; limit_val = 5; end
    @(negedge clk) limit_we = 0;
    run_burst("R6 limit5", 0, 1, 32'h2000_0010, 1, 0, 0, 5);
  endtask

  task automatic t_thr_read;  // R7 R12
    tx_level = 10; tx_high = 14;
    @(negedge clk) begin limit_we = 1; limit_val = 2; end
    @(negedge clk) limit_we = 0;
    run_burst("R7 R12 tx thr", 1, 0, 32'h300, 0, 0, 0, 4);
  endtask

  task automatic t_thr_write;  // R8
    rx_level = 20; rx_low = 16;
    run_burst("R8 rx thr", 1, 1, 32'h400, 1, 0, 0, 4);
  endtask

  task automatic t_timer;  // R9
    tx_level = 0; tx_high = 60; timer_reload = 5;
    run_burst("R9 timer", 1, 0, 32'h500, 0, 0, 0, 6);
    timer_reload = 16'hFFFF;
  endtask

  task automatic t_preempt;  // R10
    @(negedge clk) begin limit_we = 1; limit_val = 10; end
    @(negedge clk) limit_we = 0;
    run_burst("R10 preempt", 0, 0, 32'h600, 1, 1, 1, 2);
  endtask

  task automatic t_early;  // R10
    run_burst("R10 early stop", 0, 1, 32'h700, 0, 2, 2, 3);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_default_limit();
    t_prog_limit();
    t_thr_read();
    t_thr_write();
    t_timer();
    t_preempt();
    t_early();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule